// File: doc/BRIEF.md
# Interleaved Video Memory Access Translator

This block turns one linear, byte-addressed transfer into the word accesses needed by a video memory that is built from two 32-bit banks. Successive 32-bit words of the linear space live in alternate banks. A request gives a start address, a byte count and a direction. For a write, bytes arrive on an input stream with a valid/ready handshake. For a read, bytes leave on an output stream, one per cycle.

The translator splits the transfer into word-sized pieces. The first piece can start in the middle of a word, and the last piece can end before a word boundary. Each piece drives exactly one bank for one cycle, with a byte-enable mask that covers only the lanes it moves.

The start address is folded into the memory window. The byte count is cut back so that the transfer never runs past the top of the window. Before a write touches memory, the block raises one invalidate pulse for each texture-cache page that the write spans.

Top module: `vram_xlate`

## Requirements
- R1: Only the low ADDR_W bits of `start_addr` are used. Upper bits have no effect on which memory bytes are accessed.
- R2: When the address plus the length passes 2^ADDR_W, the effective length is 2^ADDR_W minus the masked address. A write accepts exactly that many input bytes, and a read delivers exactly that many output bytes.
- R3: Linear byte `a` maps to bank `a[2]`, word address `a[ADDR_W-1:3]` and byte lane `a[1:0]`. Lane k is bits 8k+7..8k of the 32-bit word.
- R4: The first access of a transfer enables lanes from `a[1:0]` upward. It stops at lane 3 or at the last byte of the transfer, whichever comes first.
- R5: Word accesses follow ascending linear order, one access per 32-bit word touched. Each access between the first and the last has the byte-enable mask 4'b1111.
- R6: When a transfer has more than one access and ends inside a word, the last access enables lanes 0 up to the lane of the final byte.
- R7: A write first pulses `inv_valid` once for each page of 2^PAGE_W bytes, from the page of the start address to the page of the last byte, in ascending order. All of these pulses come before any memory access of that write.
- R8: A read presents its bytes on `out_data` with `out_valid`, one per cycle, in ascending address order. The data are taken from the bank read port one cycle after the access.
- R9: A zero length produces no invalidate pulse and no memory access. `done` is high in the cycle after the start.
- R10: After reset `busy` and `done` are low. `busy` stays high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse, and `busy` is low in the cycle after it.
- R11: At most one bank enable is high in any cycle. The byte-enable mask is nonzero exactly when an access is made. Write lanes that are not enabled keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer; taken only while not busy |
| start_write | input | 1 | 1 for a write, 0 for a read |
| start_addr | input | IN_ADDR_W (32) | Byte start address |
| start_len | input | LEN_W (24) | Byte count |
| in_valid | input | 1 | Write byte present |
| in_data | input | 8 | Write byte |
| in_ready | output | 1 | Block takes `in_data` in this cycle if `in_valid` is high |
| out_valid | output | 1 | Read byte present |
| out_data | output | 8 | Read byte |
| inv_valid | output | 1 | Cache page invalidate pulse |
| inv_page | output | ADDR_W-PAGE_W (11) | Page number being invalidated |
| mem_en | output | 2 | Per-bank access enable |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W-3 (20) | Word address inside the bank |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write word |
| bank0_rdata | input | 32 | Bank 0 read word, valid the cycle after an access |
| bank1_rdata | input | 32 | Bank 1 read word, valid the cycle after an access |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished, one cycle |

## Verification
The bench builds the block with ADDR_W=12, LEN_W=13 and PAGE_W=8, which gives a 4 KB window with 256-byte pages and 512 words per bank. These values let short transfers reach the top of the window, so clipping can be exercised in a few dozen cycles. They also let a modest write cross several pages, so runs of invalidate pulses appear. At this size the whole memory can be compared byte for byte against the bench's linear model after every write.

// File: rtl/vx_pkg.sv
package vx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_INVAL,
    S_GATHER,
    S_WRITE,
    S_RDREQ,
    S_RDLAT,
    S_EMIT,
    S_DONE
  } vx_state_e;

  // Lanes lo .. lo+cnt-1 set.
  function automatic logic [3:0] lane_mask(input logic [1:0] lo, input logic [2:0] cnt);
    logic [3:0] m;
    m = '0;
    for (int k = 0; k < 4; k++) begin
      if (k >= int'(lo) && k < int'(lo) + int'(cnt)) m[k] = 1'b1;
    end
    return m;
  endfunction

  // Bytes moved by one piece: the room left in the word, capped by what remains.
  function automatic logic [2:0] piece_len(input logic [1:0] lo, input logic [2:0] rem_sat);
    logic [2:0] room;
    room = 3'd4 - {1'b0, lo};
    return (rem_sat < room) ? rem_sat : room;
  endfunction

  function automatic logic [31:0] put_byte(input logic [31:0] w, input logic [1:0] lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*lane +: 8] = b;
    return r;
  endfunction

  function automatic logic [7:0] get_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

endpackage

// File: rtl/vx_range.sv
module vx_range #(
  parameter int IN_ADDR_W = 32,
  parameter int ADDR_W    = 23,
  parameter int LEN_W     = 24,
  parameter int PAGE_W    = 12,
  localparam int PG_W     = ADDR_W - PAGE_W
) (
  input  logic [IN_ADDR_W-1:0] addr_in,
  input  logic [LEN_W-1:0]     len_in,
  output logic [ADDR_W-1:0]    base,
  output logic [LEN_W-1:0]     eff_len,
  output logic [PG_W-1:0]      first_page,
  output logic [PG_W-1:0]      last_page,
  output logic                 empty
);
  localparam int SUM_W = LEN_W + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(1) << ADDR_W;

  logic [SUM_W-1:0] room;
  logic [SUM_W-1:0] last_byte;

  always_comb begin
    base       = addr_in[ADDR_W-1:0];
    room       = LIMIT - SUM_W'(base);
    eff_len    = (SUM_W'(len_in) > room) ? room[LEN_W-1:0] : len_in;
    last_byte  = SUM_W'(base) + SUM_W'(eff_len) - SUM_W'(1);
    first_page = base[ADDR_W-1:PAGE_W];
    last_page  = last_byte[ADDR_W-1:PAGE_W];
    empty      = (len_in == '0);
  end
endmodule

// File: rtl/vx_chunk.sv
module vx_chunk #(
  parameter int LEN_W = 24
) (
  input  logic             first,
  input  logic [1:0]       off,
  input  logic [LEN_W-1:0] rem,
  output logic [1:0]       lo,
  output logic [2:0]       cnt,
  output logic [3:0]       be,
  output logic             last
);
  import vx_pkg::*;

  logic [2:0] rem_sat;

  always_comb begin
    rem_sat = (rem > LEN_W'(4)) ? 3'd4 : rem[2:0];
    lo      = first ? off : 2'd0;
    cnt     = piece_len(lo, rem_sat);
    be      = lane_mask(lo, cnt);
    last    = (rem == LEN_W'(cnt));
  end
endmodule

// File: rtl/vram_xlate.sv
module vram_xlate #(
  parameter int IN_ADDR_W = 32,
  parameter int ADDR_W    = 23,
  parameter int LEN_W     = 24,
  parameter int PAGE_W    = 12,
  localparam int PG_W     = ADDR_W - PAGE_W,
  localparam int WADDR_W  = ADDR_W - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_write,
  input  logic [IN_ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]     start_len,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 inv_valid,
  output logic [PG_W-1:0]      inv_page,
  output logic [1:0]           mem_en,
  output logic                 mem_we,
  output logic [WADDR_W-1:0]   mem_addr,
  output logic [3:0]           mem_be,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          bank0_rdata,
  input  logic [31:0]          bank1_rdata,
  output logic                 busy,
  output logic                 done
);
  import vx_pkg::*;

  vx_state_e          state;
  logic               cur_bank;
  logic [WADDR_W-1:0] waddr;
  logic [1:0]         off;
  logic               first;
  logic [LEN_W-1:0]   rem;
  logic [PG_W-1:0]    page;
  logic [PG_W-1:0]    page_end;
  logic [1:0]         idx;
  logic [31:0]        word;

  logic [ADDR_W-1:0]  r_base;
  logic [LEN_W-1:0]   r_eff;
  logic [PG_W-1:0]    r_first_pg;
  logic [PG_W-1:0]    r_last_pg;
  logic               r_empty;

  logic [1:0]         c_lo;
  logic [2:0]         c_cnt;
  logic [3:0]         c_be;
  logic               c_last;

  // Named internal events, also seen by the checker.
  logic               acc_fire;
  logic               idx_end;
  logic               chunk_step;
  logic [1:0]         lane_now;

  vx_range #(
    .IN_ADDR_W(IN_ADDR_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)
  ) u_range (
    .addr_in   (start_addr),
    .len_in    (start_len),
    .base      (r_base),
    .eff_len   (r_eff),
    .first_page(r_first_pg),
    .last_page (r_last_pg),
    .empty     (r_empty)
  );

  vx_chunk #(.LEN_W(LEN_W)) u_chunk (
    .first(first),
    .off  (off),
    .rem  (rem),
    .lo   (c_lo),
    .cnt  (c_cnt),
    .be   (c_be),
    .last (c_last)
  );

  assign acc_fire   = (state == S_WRITE) || (state == S_RDREQ);
  assign idx_end    = ({1'b0, idx} == (c_cnt - 3'd1));
  assign lane_now   = c_lo + idx;
  assign chunk_step = (state == S_WRITE) || ((state == S_EMIT) && idx_end);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign mem_en[b] = acc_fire && (cur_bank == 1'(b));
  end

  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = waddr;
  assign mem_be    = acc_fire ? c_be : 4'b0000;
  assign mem_wdata = word;
  assign in_ready  = (state == S_GATHER);
  assign out_valid = (state == S_EMIT);
  assign out_data  = get_byte(word, lane_now);
  assign inv_valid = (state == S_INVAL);
  assign inv_page  = page;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_bank <= 1'b0;
      waddr    <= '0;
      off      <= '0;
      first    <= 1'b0;
      rem      <= '0;
      page     <= '0;
      page_end <= '0;
      idx      <= '0;
      word     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            cur_bank <= r_base[2];
            waddr    <= r_base[ADDR_W-1:3];
            off      <= r_base[1:0];
            first    <= 1'b1;
            rem      <= r_eff;
            page     <= r_first_pg;
            page_end <= r_last_pg;
            idx      <= '0;
            word     <= '0;
            if (r_empty)          state <= S_DONE;
            else if (start_write) state <= S_INVAL;
            else                  state <= S_RDREQ;
          end
        end
        S_INVAL: begin
          if (page == page_end) state <= S_GATHER;
          else                  page  <= page + PG_W'(1);
        end
        S_GATHER: begin
          if (in_valid) begin
            word <= put_byte(word, lane_now, in_data);
            if (idx_end) begin
              idx   <= '0;
              state <= S_WRITE;
            end else begin
              idx <= idx + 2'd1;
            end
          end
        end
        S_RDREQ: state <= S_RDLAT;
        S_RDLAT: begin
          word  <= cur_bank ? bank1_rdata : bank0_rdata;
          idx   <= '0;
          state <= S_EMIT;
        end
        S_EMIT: begin
          if (!idx_end) idx <= idx + 2'd1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      // One piece finished: move to the next word of the linear stream.
      if (chunk_step) begin
        rem      <= rem - LEN_W'(c_cnt);
        first    <= 1'b0;
        cur_bank <= ~cur_bank;
        if (cur_bank) waddr <= waddr + WADDR_W'(1);
        idx      <= '0;
        word     <= '0;
        if (c_last)          state <= S_DONE;
        else if (mem_we || state == S_WRITE) state <= S_GATHER;
        else                 state <= S_RDREQ;
      end
    end
  end
endmodule

// File: rtl/vram_xlate_chk.sv
module vram_xlate_chk #(
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] start_len,
  input logic             busy,
  input logic             done,
  input logic [1:0]       mem_en,
  input logic [3:0]       mem_be,
  input logic             inv_valid,
  input logic             acc_fire
);
  logic seen_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen_acc <= 1'b0;
    else if (start && !busy)   seen_acc <= 1'b0;
    else if (mem_en != 2'b00)  seen_acc <= 1'b1;
  end

  // R7: page invalidates never follow a memory access of the same transfer
  p_inval_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !seen_acc) else $error("p_inval_first_r7");

  // R9: empty request finishes at once without touching memory
  p_empty_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_len == '0) |=> (done && !acc_fire)) else $error("p_empty_done_r9");

  // R10: done lasts one cycle and leaves the block idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)) else $error("p_done_pulse_r10");

  // R11: never two banks in one cycle
  p_one_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_en) <= 1) else $error("p_one_bank_r11");

  // R11: every access carries at least one lane, and no lane is set without an access
  p_lanes_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_en != 2'b00) == (mem_be != 4'b0000))) else $error("p_lanes_match_r11");
endmodule

bind vram_xlate vram_xlate_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .start_len(start_len),
  .busy     (busy),
  .done     (done),
  .mem_en   (mem_en),
  .mem_be   (mem_be),
  .inv_valid(inv_valid),
  .acc_fire (acc_fire)
);

// File: tb/tb_vram_xlate.sv
`timescale 1ns/1ps
module tb_vram_xlate;
  localparam int AW    = 12;
  localparam int LW    = 13;
  localparam int PW    = 8;
  localparam int SPAN  = 1 << AW;
  localparam int NWORD = SPAN / 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        start_write = 1'b0;
  logic [31:0] start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, inv_valid, mem_we, busy, done;
  logic [7:0]  out_data;
  logic [AW-PW-1:0] inv_page;
  logic [1:0]  mem_en;
  logic [AW-4:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] bank0_rdata = '0;
  logic [31:0] bank1_rdata = '0;

  always #5 clk = ~clk;

  vram_xlate #(.IN_ADDR_W(32), .ADDR_W(AW), .LEN_W(LW), .PAGE_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .start_addr(start_addr), .start_len(start_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data),
    .inv_valid(inv_valid), .inv_page(inv_page),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .bank0_rdata(bank0_rdata), .bank1_rdata(bank1_rdata),
    .busy(busy), .done(done)
  );

  // Bank memories
  logic [31:0] m0 [NWORD];
  logic [31:0] m1 [NWORD];
  // Linear reference model of the whole window
  logic [7:0]  lin [SPAN];

  always @(posedge clk) begin
    if (mem_en[0]) begin
      bank0_rdata <= m0[mem_addr];
      if (mem_we) for (int k = 0; k < 4; k++) if (mem_be[k]) m0[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
    if (mem_en[1]) begin
      bank1_rdata <= m1[mem_addr];
      if (mem_we) for (int k = 0; k < 4; k++) if (mem_be[k]) m1[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] wbyte(input int seed, input int i);
    return 8'((seed + i * 13) & 255);
  endfunction

  function automatic logic [7:0] bank_byte(input int a);
    logic [31:0] w;
    w = ((a >> 2) & 1) ? m1[a >> 3] : m0[a >> 3];
    return w[8*(a & 3) +: 8];
  endfunction

  task automatic compare_mem(input string req);
    int bad;
    int bad_a;
    bad = 0;
    bad_a = 0;
    for (int a = 0; a < SPAN; a++) begin
      if (bank_byte(a) !== lin[a]) begin
        if (bad == 0) bad_a = a;
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("memory image, first bad byte at %0h", bad_a),
        bad == 0 ? 0 : int'(bank_byte(bad_a)), bad == 0 ? 0 : int'(lin[bad_a]));
  endtask

  task automatic run_xfer(input int a_raw, input int len, input bit wr, input int seed);
    int base, eff, last, w_first, w_last, next_w, sent, n_acc;
    bit pend, seen_done, acc_seen;
    int pages[$];
    logic [7:0] rbytes[$];
    base = a_raw & (SPAN - 1);
    eff  = (len > SPAN - base) ? SPAN - base : len;
    last = base + eff - 1;
    w_first = base >> 2;
    w_last  = last >> 2;
    next_w  = w_first;
    if (wr && eff > 0) for (int p = base >> PW; p <= (last >> PW); p++) pages.push_back(p);
    if (!wr) for (int i = 0; i < eff; i++) rbytes.push_back(lin[base + i]);
    sent = 0; n_acc = 0; pend = 0; seen_done = 0; acc_seen = 0;

    @(negedge clk);
    start = 1'b1; start_write = wr; start_addr = a_raw; start_len = LW'(len);
    in_valid = wr; in_data = wbyte(seed, 0);
    for (int cyc = 0; cyc < 5000 && !seen_done; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (pend) begin sent++; in_data = wbyte(seed, sent); end
      pend = in_ready && in_valid;
      if (inv_valid) begin
        chk(!acc_seen, "R7", "invalidate after memory access", 1, 0);
        if (pages.size() == 0) chk(0, "R7", "extra invalidate page", int'(inv_page), -1);
        else begin
          int ep;
          ep = pages.pop_front();
          chk(int'(inv_page) == ep, "R7", "invalidate page", int'(inv_page), ep);
        end
      end
      if (mem_en != 2'b00) begin
        int lo, hi, ebe;
        string rq;
        acc_seen = 1;
        n_acc++;
        lo  = (next_w == w_first) ? (base & 3) : 0;
        hi  = (next_w == w_last) ? (last & 3) : 3;
        ebe = ((1 << (hi + 1)) - 1) & ~((1 << lo) - 1);
        rq  = (next_w == w_first) ? "R4" : ((next_w == w_last) ? "R6" : "R5");
        chk(int'(mem_en) == (1 << (next_w & 1)), "R3", "bank select", int'(mem_en), 1 << (next_w & 1));
        chk(int'(mem_addr) == ((next_w >> 1) & (NWORD - 1)), "R3", "bank word address",
            int'(mem_addr), (next_w >> 1) & (NWORD - 1));
        chk(mem_we == wr, "R11", "access direction", int'(mem_we), int'(wr));
        chk(int'(mem_be) == ebe, rq, "byte enables", int'(mem_be), ebe);
        next_w++;
      end else begin
        chk(mem_be == 4'b0000, "R11", "lanes without access", int'(mem_be), 0);
      end
      if (out_valid) begin
        if (rbytes.size() == 0) chk(0, "R8", "extra read byte", int'(out_data), -1);
        else begin
          logic [7:0] eb;
          eb = rbytes.pop_front();
          chk(out_data == eb, "R8", "read byte", int'(out_data), int'(eb));
        end
      end
      if (done) seen_done = 1;
    end
    if (pend) sent++;
    in_valid = 1'b0;
    chk(seen_done, "R10", "done seen", int'(seen_done), 1);
    chk(n_acc == (eff == 0 ? 0 : w_last - w_first + 1), "R5", "access count", n_acc,
        eff == 0 ? 0 : w_last - w_first + 1);
    chk(pages.size() == 0, "R7", "missing invalidate pulses", pages.size(), 0);
    chk(rbytes.size() == 0, "R8", "missing read bytes", rbytes.size(), 0);
    if (wr) chk(sent == eff, "R2", "write bytes accepted", sent, eff);
    @(negedge clk);
    chk(!done && !busy, "R10", "idle after done", {30'd0, done, busy}, 0);
    if (wr) begin
      for (int i = 0; i < eff; i++) lin[base + i] = wbyte(seed, i);
      compare_mem(wr && base != (a_raw & 32'hFFFF_FFFF) ? "R1" : "R3");
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < SPAN; a++) begin
      lin[a] = 8'((a * 7 + 3) & 255);
      if ((a >> 2) & 1) m1[a >> 3][8*(a & 3) +: 8] = lin[a];
      else              m0[a >> 3][8*(a & 3) +: 8] = lin[a];
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && mem_en == 2'b00 && !inv_valid && !in_ready && !out_valid,
        "R10", "reset state", {26'd0, busy, done, mem_en, inv_valid, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10", "idle after reset release", {30'd0, busy, done}, 0);

    run_xfer(32'h100, 16, 1, 5);        // R5 aligned words
    run_xfer(32'h203, 10, 1, 9);        // R4 R6 head and tail
    run_xfer(32'h305, 2, 1, 17);        // R4 inside one word
    run_xfer(32'h2F0, 32'h130, 1, 33);  // R7 three pages
    run_xfer(32'hFF9, 40, 1, 71);       // R2 clipped write
    run_xfer(32'h004, 4, 1, 90);        // R3 start in bank 1
    run_xfer(32'hABCD_E0A1, 9, 1, 120); // R1 upper bits dropped
    run_xfer(32'h0A0, 12, 0, 0);        // R1 R8 read back
    run_xfer(32'h1FE, 30, 0, 0);        // R8 misaligned read
    run_xfer(32'hFFE, 100, 0, 0);       // R2 clipped read
    run_xfer(32'h000, 64, 0, 0);        // R8 aligned read
    run_xfer(32'h7F0_0FF9, 7, 0, 0);    // R1 read with high bits
    run_xfer(32'h456, 0, 1, 3);         // R9 empty write
    run_xfer(32'h456, 0, 0, 0);         // R9 empty read
    compare_mem("R11");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule